// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous memory. Every control input is captured on the rising clock edge. Writes use a late-write pipeline: the address and the byte-lane enables of a write are taken on one edge, and the data for that write is taken on the following edge. The captured data is not stored in the array at once. It sits in a one-entry write buffer and reaches the array only when the next write's data arrives.

Reads compare their address against both the write that is waiting for data and the buffered write. Each 9-bit lane is taken from the newest source that holds it, so a read issued on any cycle after a write returns the written value. A write may follow a read on the next cycle, and a read may follow a write on the next cycle.

Read data leaves through a registered output with a valid flag. A separate asynchronous output-enable gates the drive indication without needing a clock.

Top module: `lw_sram`

## Requirements
- R1: Chip select `cs_n`, write strobe `we_n`, lane enables `be_n`, address and data are used only at their values on the rising clock edge. Changes between edges have no effect.
- R2: A write is signalled by `cs_n`=0 and `we_n`=0 at an edge. That edge captures the address and the lane enables. The next edge captures `din` as that write's data, whatever command is presented on that edge.
- R3: A read returns the most recently written value of each lane. It takes the value from the write still waiting for data (using `din` of the same edge), or from the buffered write, or from the array, in that priority, whenever the addresses match.
- R4: Lane i covers bits [9i+8:9i]. `be_n[i]`=0 on a write lets lane i be written. Lanes whose enable is 1 keep their old contents.
- R5: `be_n` has no effect on a read (`cs_n`=0, `we_n`=1).
- R6: A write cycle returns no read data. `q_valid` is 0 after the edge that samples a write.
- R7: A write with all bits of `be_n` at 1 changes no stored lane.
- R8: Reads and writes may alternate on consecutive edges with no idle cycle, and every read stays coherent.
- R9: After an edge that samples a deselect (`cs_n`=1) or a write, `q_valid` and `dout_oe` are 0 during the following cycle.
- R10: `dout_oe` equals `q_valid` AND NOT `oe_n` at all times. A change of `oe_n` takes effect with no clock edge.
- R11: While `rst` is high at an edge, the pending write and the write buffer are emptied, `q_valid` is cleared and `dout` is set to zero.
- R12: A read sampled at an edge puts the data on `dout` with `q_valid`=1 right after that edge. `dout` keeps its last read value through cycles that are not reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| be_n | input | LANES (4) | Lane write enables, active low, bit i for lane i |
| addr | input | ADDR_W (6) | Word address |
| din | input | LANES*LANE_W (36) | Write data, taken one edge after the write address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W (36) | Registered read data |
| q_valid | output | 1 | Read data present on dout |
| dout_oe | output | 1 | Output drive indication |

## Verification
The bench first fills the array with full-word writes. Directed sequences then check each forwarding source on its own: a read on the edge right after a write needs the forwarding from `din`, a read one cycle later needs the write buffer, and a read after a later write has committed needs the array contents. A partial byte write followed by a read shows whether lanes are merged one by one rather than as whole words. A write with no lane enabled shows whether such a write can still change memory. The random phase mixes reads, writes and deselects with random lane masks and scrambles the inputs between edges. This shows that only edge values count and that alternating read and write streams stay coherent against a plain reference memory.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int LANE_BITS_DEF = 9;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic cs_n, input logic we_n);
        if (cs_n)
            return OP_NONE;
        else if (we_n)
            return OP_READ;
        else
            return OP_WRITE;
    endfunction

endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op_now,
    output logic              pend_vld,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [LANES-1:0]  pend_ben
);

    assign op_now = decode_op(cs_n, we_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_ben  <= '0;
        end else begin
            pend_vld <= (op_now == OP_WRITE);
            if (op_now == OP_WRITE) begin
                pend_addr <= addr;
                pend_ben  <= ~be_n;
            end
        end
    end

    // write address phase is captured on its own edge
    assert_wr_addr_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |=> (pend_vld && pend_addr == $past(addr)));

    // a read leaves no pending write whatever the lane enables are
    assert_rd_no_pend_R5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n) |=> !pend_vld);

endmodule

// File: rtl/lw_wbuf.sv
module lw_wbuf #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_vld,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [LANES-1:0]  pend_ben,
    input  logic [W-1:0]      din,
    output logic              buf_vld,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LANES-1:0]  buf_ben,
    output logic [W-1:0]      buf_data,
    output logic              commit_en
);

    // the held entry retires when newer write data replaces it
    assign commit_en = pend_vld & buf_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_vld  <= 1'b0;
            buf_addr <= '0;
            buf_ben  <= '0;
            buf_data <= '0;
        end else if (pend_vld) begin
            buf_vld  <= 1'b1;
            buf_addr <= pend_addr;
            buf_ben  <= pend_ben;
            buf_data <= din;
        end
    end

    // data phase: din on the edge after the address lands in the buffer
    assert_data_phase_R2: assert property (@(posedge clk) disable iff (rst)
        pend_vld |=> (buf_vld && buf_data == $past(din) && buf_addr == $past(pend_addr)));

endmodule

// File: rtl/lw_array.sv
module lw_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_ben,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_ben[i])
                    mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/lw_read_path.sv
module lw_read_path
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_now,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [W-1:0]      arr_data,
    input  logic              pend_vld,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [LANES-1:0]  pend_ben,
    input  logic [W-1:0]      din,
    input  logic              buf_vld,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [LANES-1:0]  buf_ben,
    input  logic [W-1:0]      buf_data,
    output logic [W-1:0]      dout,
    output logic              q_valid
);

    logic         pend_hit;
    logic         buf_hit;
    logic [W-1:0] merged;

    assign pend_hit = pend_vld && (pend_addr == rd_addr);
    assign buf_hit  = buf_vld && (buf_addr == rd_addr);

    // per lane: newest source wins
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (pend_hit && pend_ben[g])
                merged[g*LANE_W +: LANE_W] = din[g*LANE_W +: LANE_W];
            else if (buf_hit && buf_ben[g])
                merged[g*LANE_W +: LANE_W] = buf_data[g*LANE_W +: LANE_W];
            else
                merged[g*LANE_W +: LANE_W] = arr_data[g*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= (op_now == OP_READ);
            if (op_now == OP_READ)
                dout <= merged;
        end
    end

    assert_full_fwd_R3: assert property (@(posedge clk) disable iff (rst)
        (op_now == OP_READ && pend_vld && pend_addr == rd_addr && (&pend_ben))
        |=> dout == $past(din));

    assert_buf_fwd_R3: assert property (@(posedge clk) disable iff (rst)
        (op_now == OP_READ && !(pend_vld && pend_addr == rd_addr) && buf_vld
         && buf_addr == rd_addr && (&buf_ben))
        |=> dout == $past(buf_data));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (op_now != OP_READ) |=> $stable(dout));

    assert_off_R9: assert property (@(posedge clk) disable iff (rst)
        (op_now != OP_READ) |=> !q_valid);

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = LANE_BITS_DEF,
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      din,
    input  logic              oe_n,
    output logic [W-1:0]      dout,
    output logic              q_valid,
    output logic              dout_oe
);

    op_e               op_now;
    logic              pend_vld;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_ben;
    logic              buf_vld;
    logic [ADDR_W-1:0] buf_addr;
    logic [LANES-1:0]  buf_ben;
    logic [W-1:0]      buf_data;
    logic              commit_en;
    logic [W-1:0]      arr_data;

    lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .be_n(be_n), .addr(addr),
        .op_now(op_now), .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_ben(pend_ben)
    );

    lw_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk(clk), .rst(rst), .pend_vld(pend_vld), .pend_addr(pend_addr),
        .pend_ben(pend_ben), .din(din), .buf_vld(buf_vld), .buf_addr(buf_addr),
        .buf_ben(buf_ben), .buf_data(buf_data), .commit_en(commit_en)
    );

    lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .wr_en(commit_en), .wr_addr(buf_addr), .wr_ben(buf_ben),
        .wr_data(buf_data), .rd_addr(addr), .rd_data(arr_data)
    );

    lw_read_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk(clk), .rst(rst), .op_now(op_now), .rd_addr(addr), .arr_data(arr_data),
        .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_ben(pend_ben), .din(din),
        .buf_vld(buf_vld), .buf_addr(buf_addr), .buf_ben(buf_ben), .buf_data(buf_data),
        .dout(dout), .q_valid(q_valid)
    );

    assign dout_oe = q_valid & ~oe_n;

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (!q_valid && dout == '0 && !pend_vld && !buf_vld));

    assert_rd_valid_R12: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n) |=> q_valid);

endmodule

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;

    localparam int AW    = 6;
    localparam int L     = 4;
    localparam int LW    = 9;
    localparam int W     = L * LW;
    localparam int DEPTH = 1 << AW;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         we_n = 1'b1;
    logic [L-1:0] be_n = '0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0] din = '0;
    logic         oe_n = 1'b0;
    logic [W-1:0] dout;
    logic         q_valid;
    logic         dout_oe;

    int checks = 0;
    int errors = 0;

    logic [W-1:0]  mdl [DEPTH];
    logic          m_pend = 1'b0;
    logic [AW-1:0] m_pend_a = '0;
    logic [L-1:0]  m_pend_ben = '0;
    logic [W-1:0]  last_q = '0;

    always #4 clk = ~clk;

    lw_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .be_n(be_n), .addr(addr),
        .din(din), .oe_n(oe_n), .dout(dout), .q_valid(q_valid), .dout_oe(dout_oe)
    );

    function automatic logic [W-1:0] merge_lanes(input logic [W-1:0] old_w,
                                                 input logic [W-1:0] new_w,
                                                 input logic [L-1:0] ben);
        logic [W-1:0] r;
        r = old_w;
        for (int i = 0; i < L; i++)
            if (ben[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, model at posedge, check at next negedge
    task automatic step(input bit c, input bit w, input logic [L-1:0] bn,
                        input logic [AW-1:0] a, input string tag);
        logic         exp_v;
        logic [W-1:0] exp_q;
        cs_n = c; we_n = w; be_n = bn; addr = a;
        din  = W'({$urandom(), $urandom()});
        @(posedge clk);
        if (m_pend) mdl[m_pend_a] = merge_lanes(mdl[m_pend_a], din, m_pend_ben);
        m_pend     = !c && !w;
        m_pend_a   = a;
        m_pend_ben = ~bn;
        exp_v = !c && w;
        exp_q = exp_v ? mdl[a] : last_q;
        // R1: scramble inputs between edges
        #1;
        cs_n = 1'($urandom()); we_n = 1'($urandom());
        be_n = L'($urandom()); addr = AW'($urandom());
        din  = W'({$urandom(), $urandom()});
        @(negedge clk);
        if (exp_v) begin
            chk(q_valid == 1'b1, {tag, " valid"}, W'(q_valid), W'(1));
            chk(dout == exp_q, tag, dout, exp_q);
            last_q = exp_q;
        end else begin
            chk(q_valid == 1'b0, "R9 valid off", W'(q_valid), W'(0));
            chk(dout == last_q, "R12 hold", dout, last_q);
        end
        chk(dout_oe == (exp_v && !oe_n), "R10 drive", W'(dout_oe), W'(exp_v && !oe_n));
    endtask

    initial begin
        #1600000;
        chk(1'b0, "watchdog", '0, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A7E_5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(q_valid == 1'b0, "R11 valid", W'(q_valid), '0);
        chk(dout == '0, "R11 dout", dout, '0);
        chk(dout_oe == 1'b0, "R11 drive", W'(dout_oe), '0);
        rst = 1'b0;

        // fill every word with a full write
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, '0, AW'(i), "R2 fill");
        step(1'b1, 1'b1, '0, '0, "R9 idle");

        // R8/R3: write then read on the next edge (din forwarding)
        step(1'b0, 1'b0, '0, 6'd5, "R2 wr");
        step(1'b0, 1'b1, '0, 6'd5, "R8 raw next edge");
        step(1'b0, 1'b1, '0, 6'd5, "R3 from buffer");
        step(1'b0, 1'b0, '0, 6'd9, "R6 wr");
        step(1'b0, 1'b1, '0, 6'd5, "R3 buffer at commit");
        step(1'b0, 1'b1, '0, 6'd5, "R3 from array");
        step(1'b0, 1'b1, '0, 6'd9, "R3 second write");

        // R4: partial lanes 0 and 2
        step(1'b0, 1'b0, 4'b1010, 6'd12, "R4 wr");
        step(1'b0, 1'b1, '0, 6'd12, "R4 merge from din");
        step(1'b0, 1'b0, 4'b0111, 6'd12, "R4 wr lane3");
        step(1'b0, 1'b1, '0, 6'd12, "R4 merge buf and din");
        step(1'b0, 1'b1, '0, 6'd12, "R4 merge buf");

        // R7: no lane enabled
        step(1'b0, 1'b0, 4'b1111, 6'd20, "R7 wr");
        step(1'b0, 1'b1, '0, 6'd20, "R7 unchanged");
        step(1'b0, 1'b0, '0, 6'd33, "R7 wr other");
        step(1'b0, 1'b1, '0, 6'd20, "R7 unchanged after commit");

        // R5: lane enables on reads
        step(1'b0, 1'b1, 4'b1111, 6'd33, "R5 read be ones");
        step(1'b0, 1'b1, 4'b0101, 6'd12, "R5 read be mixed");

        // R1 and R10
        step(1'b0, 1'b1, '0, 6'd40, "R1 sampled read");
        oe_n = 1'b1; #1;
        chk(dout_oe == 1'b0, "R10 async off", W'(dout_oe), '0);
        oe_n = 1'b0; #1;
        chk(dout_oe == 1'b1, "R10 async on", W'(dout_oe), W'(1));
        step(1'b1, 1'b0, '0, 6'd40, "R9 deselect");
        step(1'b0, 1'b1, '0, 6'd41, "R12 read");
        step(1'b0, 1'b0, '0, 6'd41, "R6 wr after rd");
        step(1'b0, 1'b1, '0, 6'd41, "R8 rd after wr");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int sel;
            bit c, w;
            sel = $urandom_range(0, 9);
            c = (sel >= 8);
            w = (sel < 4);
            oe_n = ($urandom_range(0, 7) == 0);
            step(c, w, ($urandom_range(0, 1) == 0) ? L'(0) : L'($urandom()),
                 AW'($urandom_range(0, 15)), "R8 random");
        end
        oe_n = 1'b0;
        step(1'b1, 1'b1, '0, '0, "R9 idle end");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule